// File: doc/BRIEF.md
# Hex Code to Seven-Segment Glyph Decoder

The block turns a 4-bit code into the seven drive lines of a single segment display. The mapping is combinational, and every one of the sixteen codes has a glyph. Codes 0 to 9 draw decimal digits. The digit 6 has no top bar and the digit 9 has no bottom bar. Codes 10 to 14 draw fixed symbol shapes, and code 15 leaves the display dark. A drive line at 1 lights its segment.

The combinational result appears on `seg_o`. A registered copy appears on `seg_q_o` one clock later, for use where the display path has to be timed from a flop. An active-low asynchronous reset clears only that register.

Top module: `seg7_decoder`

## Requirements
- R1: The segment vector is active-high (1 lights a segment), with segment a in bit 6, b in bit 5, c in bit 4, d in bit 3, e in bit 2, f in bit 1 and g in bit 0; only code 8 lights all seven.
- R2: Codes 0, 1, 2, 3, 4, 5 give seg_o (bits 6..0) = 1111110, 0110000, 1101101, 1111001, 0110011, 1011011.
- R3: Code 6 gives 0011111 (segment a dark) and code 7 gives 1110000.
- R4: Code 8 gives 1111111 and code 9 gives 1110011 (segment d dark).
- R5: Codes 10, 11, 12, 13, 14 give 0001101, 0011001, 0100011, 1001011, 0001111.
- R6: Code 15 gives 0000000, and no other code leaves every segment dark.
- R7: With reset released, seg_q_o equals the seg_o value of the previous clock cycle.
- R8: While rst_ni is low, seg_q_o is 0000000 whatever the code.
- R9: seg_o depends only on the present code: a repeated code gives the same pattern regardless of earlier codes or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| code_i | input | 4 | Code to display, bit 3 most significant |
| seg_o | output | 7 | Combinational segment drives, a in bit 6 to g in bit 0 |
| seg_q_o | output | 7 | Registered segment drives, one cycle behind seg_o |

## Verification
The assertions assume that code_i always carries a known 2-state value and changes only between clock edges. Under that assumption the combinational glyph is settled at each sampling edge, so comparing seg_q_o with the previous seg_o is meaningful. The stimulus drives every code on the falling edge from 2-state variables and never from unknowns. It covers ascending, descending, repeated and pseudo-random code orders, and it applies one reset while the design is running.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEG_N  = 7;
  localparam int unsigned SEG_A  = SEG_N - 1;
  localparam int unsigned SEG_D  = SEG_N - 4;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  localparam seg_t SEG_DARK = '0;

  // bit order: a b c d e f g
  function automatic seg_t glyph(code_t c);
    unique case (c)
      4'd0:  glyph = 7'b111_1110;
      4'd1:  glyph = 7'b011_0000;
      4'd2:  glyph = 7'b110_1101;
      4'd3:  glyph = 7'b111_1001;
      4'd4:  glyph = 7'b011_0011;
      4'd5:  glyph = 7'b101_1011;
      4'd6:  glyph = 7'b001_1111;
      4'd7:  glyph = 7'b111_0000;
      4'd8:  glyph = 7'b111_1111;
      4'd9:  glyph = 7'b111_0011;
      4'd10: glyph = 7'b000_1101;
      4'd11: glyph = 7'b001_1001;
      4'd12: glyph = 7'b010_0011;
      4'd13: glyph = 7'b100_1011;
      4'd14: glyph = 7'b000_1111;
      default: glyph = SEG_DARK;
    endcase
  endfunction
endpackage

// File: rtl/seg7_glyph_map.sv
module seg7_glyph_map
  import seg7_pkg::*;
(
  input  code_t code_i,
  output seg_t  seg_o
);
  always_comb seg_o = glyph(code_i);
endmodule

// File: rtl/seg7_out_stage.sv
module seg7_out_stage
  import seg7_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  seg_t d_i,
  output seg_t q_o
);
  generate
    if (REG_OUT) begin : g_reg
      seg_t q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_r <= SEG_DARK;
        else         q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_bypass
      // clk_i and rst_ni are unused in this variant
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
  import seg7_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [SEG_N-1:0]  seg_o,
  output logic [SEG_N-1:0]  seg_q_o
);
  seg_t seg_w;

  seg7_glyph_map u_map (
    .code_i (code_i),
    .seg_o  (seg_w)
  );

  seg7_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (seg_w),
    .q_o    (seg_q_o)
  );

  assign seg_o = seg_w;
endmodule

// File: rtl/seg7_decoder_chk.sv
module seg7_decoder_chk
  import seg7_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] code_i,
  input logic [6:0] seg_o,
  input logic [6:0] seg_q_o
);
  // R1
  all_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(seg_o) == SEG_N) |-> (code_i == 4'd8));

  // R3
  six_no_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 4'd6) |-> !seg_o[SEG_A]);

  // R4
  nine_no_d_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 4'd9) |-> !seg_o[SEG_D]);

  // R6
  dark_only_f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o == 7'd0) |-> (code_i == 4'hF));

  // R7
  reg_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (seg_q_o == $past(seg_o)));

  // R9
  stable_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(code_i) |-> $stable(seg_o));

  // R8
  always @(negedge clk_i) begin
    if (!rst_ni) reset_dark_chk: assert (seg_q_o == 7'd0);
  end
endmodule

bind seg7_decoder seg7_decoder_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .code_i  (code_i),
  .seg_o   (seg_o),
  .seg_q_o (seg_q_o)
);

// File: tb/seg7_decoder_tb_top.sv
module seg7_decoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] code_i = 4'd0;
  logic [6:0] seg_o, seg_q_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [3:0] code; logic [6:0] exp; } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i; // 50 MHz

  seg7_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i),
    .seg_o(seg_o), .seg_q_o(seg_q_o)
  );

  function automatic logic [6:0] ref_seg(logic [3:0] c);
    logic [6:0] t [16] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33, 7'h5B,
                           7'h1F, 7'h70, 7'h7F, 7'h73, 7'h0D, 7'h19,
                           7'h23, 7'h4B, 7'h0F, 7'h00};
    return t[c];
  endfunction

  function automatic string req_of(logic [3:0] c);
    if (c <= 4'd5)  return "R2";
    if (c <= 4'd7)  return "R3";
    if (c <= 4'd9)  return "R4";
    if (c <= 4'd14) return "R5";
    return "R6";
  endfunction

  task automatic drive(logic [3:0] c);
    @(negedge clk_i);
    code_i = c;
    sb_q.push_back('{code: c, exp: ref_seg(c)});
  endtask

  // monitor: after each rising edge, seg_q_o holds the code driven before it
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_vec++;
      if (seg_o !== it.exp) begin
        n_bad++;
        $display("FAIL %s/R9 comb code=%0d actual=%b expected=%b",
                 req_of(it.code), it.code, seg_o, it.exp);
      end
      n_vec++;
      if (seg_q_o !== it.exp) begin
        n_bad++;
        $display("FAIL R7 reg code=%0d actual=%b expected=%b",
                 it.code, seg_q_o, it.exp);
      end
    end
  end

  task automatic check_reset_dark(string tag);
    n_vec++;
    if (seg_q_o !== 7'd0) begin
      n_bad++;
      $display("FAIL R8 %s actual=%b expected=0000000", tag, seg_q_o);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    logic [3:0] lfsr;
    code_i = 4'd8;
    #25;
    check_reset_dark("in reset, code 8");      // R8
    n_vec++;                                    // R1: comb path live in reset
    if (seg_o !== 7'h7F) begin
      n_bad++;
      $display("FAIL R1 code 8 actual=%b expected=1111111", seg_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 16; i++) drive(4'(i));      // ascending, R2..R6
    for (int i = 15; i >= 0; i--) drive(4'(i));     // descending
    for (int i = 0; i < 4; i++) drive(4'd6);        // R9 repeats
    for (int i = 0; i < 4; i++) drive(4'd9);
    lfsr = 4'b1001;
    for (int i = 0; i < 60; i++) begin
      drive(lfsr);
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    end
    @(negedge clk_i);
    @(negedge clk_i);
    // mid-run reset with a lit code on the input
    code_i = 4'd8;
    #3;
    rst_ni = 1'b0;
    #2;
    check_reset_dark("async mid-run");          // R8
    @(negedge clk_i);
    check_reset_dark("held over edge");         // R8
    n_vec++;                                    // R9: same code, same glyph after reset
    if (seg_o !== 7'h7F) begin
      n_bad++;
      $display("FAIL R9 code 8 after reset actual=%b expected=1111111", seg_o);
    end
    rst_ni = 1'b1;
    drive(4'd15);
    drive(4'd13);
    drive(4'd0);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule